// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces every timing signal a serial audio port needs from one fast input clock: an optional master clock, a bit clock, a word-select (channel) signal and a one-cycle sample strobe. A programmable linear divider divides the input clock by `2*div + odd`, so both even and odd ratios are available. Its output is reshaped into a regular square wave. All outputs are registered signals in the input clock domain.

When the master-clock path is selected, the reshaped divider output is driven out as the master clock. The bit clock is then that clock divided by 8 (16-bit channels) or by 4 (32-bit channels), so one stereo frame always spans 256 master clocks. When the master-clock path is off, the divider output is used directly as the bit clock and the master-clock pin stays low. A frame holds a left and a right channel, giving 32 or 64 bit clocks per frame.

Settings are captured only while `run_i` is low. Raising `run_i` restarts every counter from a fixed phase. A divide value below 2 is refused: the error flag rises and all clock outputs stay low.

Top module: `audio_clkgen`

## Requirements
- R1: The divider period is exactly `2*div_i + odd_i` input clocks. It shows on `bclk_o` when the master-clock path is off and on `mclk_o` when it is on.
- R2: Each divider period is high for `div_i + odd_i` input clocks and low for `div_i` input clocks. For odd ratios the extra cycle falls in the high phase.
- R3: With `mclk_en_i` = 1, `mclk_o` carries the reshaped divider output.
- R4: With `mclk_en_i` = 1, the `bclk_o` period is 8 master-clock periods when `long_ch_i` = 0 and 4 when `long_ch_i` = 1. Every `bclk_o` edge coincides with a rising `mclk_o` edge.
- R5: With `mclk_en_i` = 0, `bclk_o` is the reshaped divider output and `mclk_o` stays 0.
- R6: A frame lasts 32 bit clocks when `long_ch_i` = 0 and 64 when `long_ch_i` = 1. `strobe_o` is high for exactly one input clock per frame, in the cycle where `bclk_o` falls. With the master clock on, the strobe period is 256 master-clock periods.
- R7: `ws_o` changes only together with a falling `bclk_o`. It is 0 for the left channel and 1 for the right. It rises one bit period before the right channel's first bit, which is half a frame minus one bit after the strobe. It stays high for half a frame. `strobe_o` only occurs with `ws_o` = 0.
- R8: With `run_i` = 1 and a captured `div_i` below 2, `cfg_err_o` is 1 and `mclk_o`, `bclk_o`, `ws_o` and `strobe_o` stay 0.
- R9: Changes to `div_i`, `odd_i`, `mclk_en_i` and `long_ch_i` while `run_i` = 1 have no effect. The values present in the last cycle with `run_i` = 0 stay in force.
- R10: In direct mode, on the first clock edge with `run_i` = 1, `bclk_o` goes high. The first `strobe_o` appears after edge number `div_i + odd_i + 1`, counting that first edge as 1.
- R11: After reset, and whenever `run_i` = 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input (peripheral) clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Generator enable; settings captured while low |
| div_i | input | DIV_W | Linear divide value (legal values are 2 and above) |
| odd_i | input | 1 | Adds one input clock to the divide ratio |
| mclk_en_i | input | 1 | Selects the master-clock path |
| long_ch_i | input | 1 | 0: 16-bit channels, 1: 32-bit channels |
| mclk_o | output | 1 | Master clock (0 when the path is off) |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left channel |
| strobe_o | output | 1 | One-cycle pulse at the start of each left channel |
| cfg_err_o | output | 1 | Running with an illegal divide value |

## Verification
The hardest situation to reach from the ports is a settings change while the generator is running. The design should ignore it, but its effect would only show as a drift in later periods. The bench starts a known ratio, then drives a very different divide value and flips the path and channel-length selects mid-run. It then measures full bit-clock periods again and watches the master-clock pin. The restart phase is also checked, by counting edges from the enable to the first strobe.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  typedef enum logic {
    PATH_DIRECT = 1'b0,
    PATH_MCLK   = 1'b1
  } clk_path_e;
endpackage

// File: rtl/acg_linear_div.sv
module acg_linear_div #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  output logic             div_q_o,
  output logic             start_o,
  output logic             div_nxt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, last_cnt, high_len;
  logic             run_q;

  always_comb begin
    last_cnt  = {div_i, odd_i} - CNT_W'(1);
    high_len  = {1'b0, div_i} + CNT_W'(odd_i);
    start_o   = active_i && (!run_q || (cnt_q == last_cnt));
    cnt_nxt   = start_o ? '0 : cnt_q + CNT_W'(1);
    div_nxt_o = active_i && (cnt_nxt < high_len);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !active_i) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      div_q_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      run_q   <= 1'b1;
      div_q_o <= div_nxt_o;
    end
  end

  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> div_q_o); // R2
  AST_COUNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && run_q) |-> (cnt_q <= last_cnt)); // R1
endmodule

// File: rtl/acg_bclk_stage.sv
module acg_bclk_stage
  import audio_clkgen_pkg::*;
#(
  parameter int SHORT_CH = 16,
  parameter int LONG_CH  = 32,
  parameter int MCLK_FS  = 256,
  localparam int K_SHORT = MCLK_FS / (2 * SHORT_CH),
  localparam int K_LONG  = MCLK_FS / (2 * LONG_CH),
  localparam int PC_W    = (K_SHORT > 2) ? $clog2(K_SHORT) : 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  clk_path_e path_i,
  input  logic      long_i,
  input  logic      div_start_i,
  input  logic      div_nxt_i,
  input  logic      div_q_i,
  output logic      bclk_o,
  output logic      fall_o
);
  logic [PC_W-1:0] pcnt_q, pcnt_nxt, k_last, k_half;
  logic            run_q, bclk_nxt;

  always_comb begin
    k_last = long_i ? PC_W'(K_LONG - 1) : PC_W'(K_SHORT - 1);
    k_half = long_i ? PC_W'(K_LONG / 2) : PC_W'(K_SHORT / 2);
    if (!run_q)
      pcnt_nxt = '0;
    else if (div_start_i)
      pcnt_nxt = (pcnt_q == k_last) ? '0 : pcnt_q + PC_W'(1);
    else
      pcnt_nxt = pcnt_q;
    if (!active_i)
      bclk_nxt = 1'b0;
    else if (path_i == PATH_MCLK)
      bclk_nxt = (pcnt_nxt < k_half);
    else
      bclk_nxt = div_nxt_i;
    fall_o = active_i && bclk_o && !bclk_nxt;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !active_i) begin
      pcnt_q <= '0;
      run_q  <= 1'b0;
      bclk_o <= 1'b0;
    end else begin
      pcnt_q <= pcnt_nxt;
      run_q  <= 1'b1;
      bclk_o <= bclk_nxt;
    end
  end

  AST_BCLK_ON_MCLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && path_i == PATH_MCLK && !$stable(bclk_o)) |-> $rose(div_q_i)); // R4
endmodule

// File: rtl/acg_frame_stage.sv
module acg_frame_stage #(
  parameter int SHORT_CH = 16,
  parameter int LONG_CH  = 32,
  localparam int SLOT_W  = $clog2(2 * LONG_CH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic long_i,
  input  logic fall_i,
  output logic ws_o,
  output logic strobe_o
);
  logic [SLOT_W-1:0] slot_q, slot_nxt, slot_last, ws_from;

  always_comb begin
    slot_last = long_i ? SLOT_W'(2 * LONG_CH - 1) : SLOT_W'(2 * SHORT_CH - 1);
    ws_from   = long_i ? SLOT_W'(LONG_CH - 1) : SLOT_W'(SHORT_CH - 1);
    slot_nxt  = ((slot_q == slot_last) || (slot_q == '1)) ? '0 : slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !active_i) begin
      slot_q   <= '1;
      ws_o     <= 1'b0;
      strobe_o <= 1'b0;
    end else if (fall_i) begin
      slot_q   <= slot_nxt;
      ws_o     <= (slot_nxt >= ws_from) && (slot_nxt != slot_last);
      strobe_o <= (slot_nxt == '0);
    end else begin
      strobe_o <= 1'b0;
    end
  end

  AST_STROBE_IN_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !ws_o); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R6
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SHORT_CH = 16,
  parameter int LONG_CH  = 32,
  parameter int MCLK_FS  = 256,
  localparam int MIN_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mclk_en_i,
  input  logic             long_ch_i,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             strobe_o,
  output logic             cfg_err_o
);
  logic [DIV_W-1:0] div_cfg;
  logic             odd_cfg, long_cfg;
  clk_path_e        path_cfg;
  logic             bad_cfg, active;
  logic             div_q, div_start, div_nxt, bclk_fall;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_cfg  <= '0;
      odd_cfg  <= 1'b0;
      long_cfg <= 1'b0;
      path_cfg <= PATH_DIRECT;
    end else if (!run_i) begin
      div_cfg  <= div_i;
      odd_cfg  <= odd_i;
      long_cfg <= long_ch_i;
      path_cfg <= mclk_en_i ? PATH_MCLK : PATH_DIRECT;
    end
  end

  always_comb begin
    bad_cfg   = (div_cfg < DIV_W'(MIN_DIV));
    active    = run_i && !bad_cfg;
    cfg_err_o = run_i && bad_cfg;
    mclk_o    = div_q && (path_cfg == PATH_MCLK);
  end

  acg_linear_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .div_i     (div_cfg),
    .odd_i     (odd_cfg),
    .div_q_o   (div_q),
    .start_o   (div_start),
    .div_nxt_o (div_nxt)
  );

  acg_bclk_stage #(.SHORT_CH(SHORT_CH), .LONG_CH(LONG_CH), .MCLK_FS(MCLK_FS)) u_bclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .path_i      (path_cfg),
    .long_i      (long_cfg),
    .div_start_i (div_start),
    .div_nxt_i   (div_nxt),
    .div_q_i     (div_q),
    .bclk_o      (bclk_o),
    .fall_o      (bclk_fall)
  );

  acg_frame_stage #(.SHORT_CH(SHORT_CH), .LONG_CH(LONG_CH)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .long_i   (long_cfg),
    .fall_i   (bclk_fall),
    .ws_o     (ws_o),
    .strobe_o (strobe_o)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> ($stable(div_cfg) && $stable(odd_cfg) && $stable(long_cfg) && $stable(path_cfg))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!bclk_o && !ws_o && !strobe_o && !mclk_o)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!bclk_o && !mclk_o)); // R8
  AST_WS_ON_BCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active) && !$stable(ws_o)) |-> $fell(bclk_o)); // R7
  AST_STROBE_ON_BCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $fell(bclk_o)); // R6
endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] div = 8'd2;
  logic       odd = 1'b0;
  logic       mclk_en = 1'b0;
  logic       long_ch = 1'b0;
  logic       mclk, bclk, ws, strobe, err;
  int         checks = 0;
  int         failures = 0;
  int         cycles = 0;

  always #2.5 clk = ~clk;

  audio_clkgen i_audio_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_i(div), .odd_i(odd),
    .mclk_en_i(mclk_en), .long_ch_i(long_ch), .mclk_o(mclk), .bclk_o(bclk),
    .ws_o(ws), .strobe_o(strobe), .cfg_err_o(err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig(int sel);
    case (sel)
      0: return mclk;
      1: return bclk;
      2: return ws;
      default: return strobe;
    endcase
  endfunction

  task automatic wait_rise(int sel);
    bit p;
    do begin
      p = sig(sel);
      @(negedge clk);
    end while (!(!p && sig(sel)));
  endtask

  task automatic period(int sel, output int per);
    bit p;
    wait_rise(sel);
    per = 0;
    do begin
      p = sig(sel);
      @(negedge clk);
      per++;
    end while (!(!p && sig(sel)));
  endtask

  task automatic hilo(int sel, output int hi, output int lo);
    wait_rise(sel);
    hi = 0;
    while (sig(sel)) begin @(negedge clk); hi++; end
    lo = 0;
    while (!sig(sel)) begin @(negedge clk); lo++; end
  endtask

  task automatic start(int d, bit o, bit m, bit l);
    run = 1'b0; div = 8'(d); odd = o; mclk_en = m; long_ch = l;
    repeat (3) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 reset bclk", bclk, 0);
    check("R11 reset mclk", mclk, 0);
    check("R11 reset ws", ws, 0);
    check("R11 reset strobe", strobe, 0);
    check("R11 reset err", err, 0);
  endtask

  task automatic t_direct(int d, bit o, bit l);
    int r, f, per, hi, lo, n, mseen;
    r = 2 * d + o;
    f = l ? 64 : 32;
    start(d, o, 1'b0, l);
    period(1, per);
    check("R1 direct bclk period", per, r);
    hilo(1, hi, lo);
    check("R2 high phase", hi, d + o);
    check("R2 low phase", lo, d);
    mseen = 0;
    period(3, per);
    check("R6 strobe period frames", per, f * r);
    wait_rise(3);
    check("R7 ws low at strobe", ws, 0);
    n = 0;
    while (!ws) begin @(negedge clk); n++; if (mclk) mseen = 1; end
    check("R7 strobe to ws rise", n, (f / 2 - 1) * r);
    n = 0;
    while (ws) begin @(negedge clk); n++; if (mclk) mseen = 1; end
    check("R7 ws high length", n, (f / 2) * r);
    check("R5 mclk idle in direct mode", mseen, 0);
    wait_rise(3);
    @(negedge clk);
    check("R6 strobe one cycle", strobe, 0);
  endtask

  task automatic t_mclk(int d, bit o, bit l);
    int r, k, per, hi, lo;
    r = 2 * d + o;
    k = l ? 4 : 8;
    start(d, o, 1'b1, l);
    period(0, per);
    check("R3 mclk period", per, r);
    hilo(0, hi, lo);
    check("R3 mclk high phase", hi, d + o);
    period(1, per);
    check("R4 bclk per mclk", per, k * r);
    period(3, per);
    check("R6 strobe is 256 mclk", per, 256 * r);
  endtask

  task automatic t_first(int d, bit o);
    int n;
    start(d, o, 1'b0, 1'b0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check("R10 bclk high after first edge", bclk, 1);
    end while (!strobe && n < 1000);
    check("R10 first strobe edge", n, d + o + 1);
  endtask

  task automatic t_illegal(int d);
    int seen;
    start(d, 1'b1, 1'b1, 1'b0);
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (mclk || bclk || ws || strobe) seen = 1;
    end
    check("R8 error flag", err, 1);
    check("R8 outputs quiet", seen, 0);
  endtask

  task automatic t_locked();
    int per, mseen;
    start(2, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    div = 8'd9; odd = 1'b1; mclk_en = 1'b1; long_ch = 1'b1;
    repeat (3) @(negedge clk);
    period(1, per);
    check("R9 bclk ratio kept", per, 4);
    period(3, per);
    check("R9 frame length kept", per, 128);
    mseen = 0;
    repeat (40) begin @(negedge clk); if (mclk) mseen = 1; end
    check("R9 mclk stays off", mseen, 0);
  endtask

  task automatic t_stop();
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 stopped bclk", bclk, 0);
    check("R11 stopped ws", ws, 0);
    check("R11 stopped err", err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct(2, 1'b0, 1'b0);
    t_direct(3, 1'b1, 1'b0);
    t_direct(5, 1'b1, 1'b1);
    t_mclk(3, 1'b1, 1'b0);
    t_mclk(2, 1'b0, 1'b1);
    t_first(2, 1'b0);
    t_first(4, 1'b1);
    t_illegal(1);
    t_illegal(0);
    t_stop();
    t_locked();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule